// File: doc/BRIEF.md
# Two-Threshold Strip Cluster Finder

This block performs zero suppression on a stream of pedestal- and common-mode-corrected strip values. Each strip arrives with its own noise figure. The block compares the signal with a multiple of that noise. A group of two or more adjacent strips that each clear a lower threshold is kept as a cluster. A strip with no passing neighbours is kept only when it clears a second, higher threshold. Everything else is discarded.

Each kept cluster becomes a byte record in an internal 2048-byte FIFO. The record holds the index of its first strip, its width and one compressed 8-bit charge per strip. The bytes of a cluster are written ahead of time while the cluster grows. They become visible to the reader only when the cluster closes and is accepted. A downstream event builder therefore never sees a partial record. When an accepted cluster cannot fit in the FIFO, the whole record is dropped and a sticky flag is raised.

Top module: `strip_cluster_finder`

## Requirements
- R1: A strip passes the lower test when 4*charge > thr_lo*noise, a strict comparison. thr_lo and thr_hi are unsigned counts of quarter-noise units.
- R2: A run of two or more consecutive passing strips in one frame produces exactly one record. A single failing strip ends a run, so two runs separated by it give two records.
- R3: A run of one strip produces a record only when 4*charge > thr_hi*noise. Otherwise it produces no output.
- R4: A record is byte 0 = index of the first strip (bit 7 zero), byte 1 = width in strips, then one charge byte per strip in strip order.
- R5: A charge byte is 0 for charge <= 0, the charge itself for 1..253, 254 for 254..1023, and 255 for 1024 and above.
- R6: The strip index is 0 for the first valid strip after reset or after a strip with s_last set. It rises by one for each further valid strip.
- R7: The strip marked s_last closes any open run and is included in it when it passes. The next frame's first strip starts a new run.
- R8: The FIFO holds 2048 bytes and returns them in write order. f_nempty is high while unread bytes exist, and f_ren with f_nempty high pops one byte at the clock edge.
- R9: An accepted record that does not fit in the free FIFO space is dropped whole, and ovf_flag is set and held until reset. A record that does fit exactly is stored, and a rejected run never sets the flag.
- R10: Cycles with s_valid low are ignored: they neither advance the strip index nor break a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_lo | input | 6 | Neighbour threshold, quarter-noise units |
| thr_hi | input | 6 | Single-strip threshold, quarter-noise units |
| s_valid | input | 1 | Strip sample valid |
| s_last | input | 1 | Marks the last strip of a frame |
| s_charge | input | 12 | Corrected strip charge, signed |
| s_noise | input | 8 | Strip noise, unsigned |
| f_ren | input | 1 | FIFO pop request |
| f_rdata | output | 8 | FIFO head byte |
| f_nempty | output | 1 | FIFO holds unread bytes |
| ovf_flag | output | 1 | Sticky lost-record flag |

## Verification
The embedded properties watch several conditions on every cycle:
- the committed FIFO fill never exceeds its capacity;
- the empty status cannot drop without a pop;
- the overflow flag never clears;
- idle input cycles leave the strip index untouched;
- a frame end always leaves no run open;
- any strip passing the lower test yields a nonzero charge code;
- every committed header carries a nonzero width.

Whether the right strips are grouped, whether the single-strip gate and the exact threshold edges are honoured, and whether the record bytes are correct can only be shown by the bench scenarios. These scenarios compare every byte the FIFO returns with a model of the rules. They also cover the exact-fit and one-record-too-many boundaries of the FIFO.

// File: rtl/scf_pkg.sv
package scf_pkg;

    localparam int unsigned CODE_LIN_MAX = 253;
    localparam int unsigned CODE_MID_MAX = 1023;
    localparam logic [7:0]  CODE_MID     = 8'd254;
    localparam logic [7:0]  CODE_TOP     = 8'd255;

    // Map a signed charge onto one byte: clamp negatives, keep small
    // values exact, use two saturation codes for large deposits.
    function automatic logic [7:0] squeeze(input logic signed [31:0] v);
        if (v <= 0)
            return 8'd0;
        else if (v <= $signed(CODE_LIN_MAX))
            return v[7:0];
        else if (v <= $signed(CODE_MID_MAX))
            return CODE_MID;
        else
            return CODE_TOP;
    endfunction

endpackage

// File: rtl/scf_judge.sv
module scf_judge #(
    parameter int CHG_W    = 12,
    parameter int NOISE_W  = 8,
    parameter int THR_W    = 6,
    parameter int THR_FRAC = 2
) (
    input  logic signed [CHG_W-1:0]   charge,
    input  logic        [NOISE_W-1:0] noise,
    input  logic        [THR_W-1:0]   thr_lo,
    input  logic        [THR_W-1:0]   thr_hi,
    output logic                      pass_lo,
    output logic                      pass_hi,
    output logic        [7:0]         code
);
    import scf_pkg::*;

    localparam int PW = CHG_W + THR_FRAC + THR_W + NOISE_W + 1;

    logic signed [PW-1:0] lhs_d;
    logic signed [PW-1:0] rhs_lo_d;
    logic signed [PW-1:0] rhs_hi_d;

    // Division-free signal-over-noise test: scale the charge by the
    // fractional weight of the threshold and compare with thr*noise.
    always_comb begin
        lhs_d    = PW'(charge) <<< THR_FRAC;
        rhs_lo_d = $signed(PW'(thr_lo) * PW'(noise));
        rhs_hi_d = $signed(PW'(thr_hi) * PW'(noise));
        pass_lo  = lhs_d > rhs_lo_d;
        pass_hi  = lhs_d > rhs_hi_d;
        code     = squeeze(32'(charge));
    end

endmodule

// File: rtl/scf_store.sv
module scf_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          c_we,
    input  logic [AW-1:0] c_addr,
    input  logic [7:0]    c_data,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_data0,
    input  logic [7:0]    h_data1,
    input  logic [AW-1:0] r_addr,
    output logic [7:0]    r_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] h_addr1_d;

    always_comb h_addr1_d = h_addr + AW'(1);

    // One charge port plus a two-byte header port; the controller
    // never aims them at the same byte in one cycle.
    always_ff @(posedge clk) begin
        if (c_we) mem_q[c_addr]    <= c_data;
        if (h_we) mem_q[h_addr]    <= h_data0;
        if (h_we) mem_q[h_addr1_d] <= h_data1;
    end

    assign r_data = mem_q[r_addr];

endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder #(
    parameter int CHG_W      = 12,
    parameter int NOISE_W    = 8,
    parameter int THR_W      = 6,
    parameter int THR_FRAC   = 2,
    parameter int IDX_W      = 7,
    parameter int FIFO_BYTES = 2048
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic        [THR_W-1:0]   thr_lo,
    input  logic        [THR_W-1:0]   thr_hi,
    input  logic                      s_valid,
    input  logic                      s_last,
    input  logic signed [CHG_W-1:0]   s_charge,
    input  logic        [NOISE_W-1:0] s_noise,
    input  logic                      f_ren,
    output logic        [7:0]         f_rdata,
    output logic                      f_nempty,
    output logic                      ovf_flag
);
    localparam int AW    = $clog2(FIFO_BYTES);
    localparam int PW    = AW + 1;
    localparam int WID_W = IDX_W + 1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             open;
        logic             drop;
        logic             hi1;
        logic [IDX_W-1:0] first;
        logic [WID_W-1:0] wid;
        logic [PW-1:0]    st;
        logic [PW-1:0]    sp;
        logic [PW-1:0]    wr;
        logic [PW-1:0]    rd;
        logic             ovf;
    } state_t;

    state_t q, d;

    logic          pass_lo, pass_hi;
    logic [7:0]    code;
    logic          c_we, h_we, close_d;
    logic [AW-1:0] c_addr, h_addr;
    logic [7:0]    h_d0, h_d1;

    scf_judge #(
        .CHG_W(CHG_W), .NOISE_W(NOISE_W), .THR_W(THR_W), .THR_FRAC(THR_FRAC)
    ) u_judge (
        .charge (s_charge),
        .noise  (s_noise),
        .thr_lo (thr_lo),
        .thr_hi (thr_hi),
        .pass_lo(pass_lo),
        .pass_hi(pass_hi),
        .code   (code)
    );

    scf_store #(.AW(AW)) u_store (
        .clk    (clk),
        .c_we   (c_we),
        .c_addr (c_addr),
        .c_data (code),
        .h_we   (h_we),
        .h_addr (h_addr),
        .h_data0(h_d0),
        .h_data1(h_d1),
        .r_addr (q.rd[AW-1:0]),
        .r_data (f_rdata)
    );

    // True when the FIFO would still hold everything up to 'upto'
    // without touching unread bytes.
    function automatic logic fits(input logic [PW-1:0] upto, input logic [PW-1:0] rd);
        return (upto - rd) <= PW'(FIFO_BYTES);
    endfunction

    always_comb begin
        d       = q;
        c_we    = 1'b0;
        c_addr  = '0;
        h_we    = 1'b0;
        h_addr  = '0;
        h_d0    = '0;
        h_d1    = '0;
        close_d = 1'b0;

        if (f_ren && (q.wr != q.rd))
            d.rd = q.rd + PW'(1);

        if (s_valid) begin
            d.idx = s_last ? '0 : q.idx + IDX_W'(1);
            if (pass_lo) begin
                if (!q.open) begin
                    d.open  = 1'b1;
                    d.first = q.idx;
                    d.hi1   = pass_hi;
                    d.wid   = WID_W'(1);
                    d.st    = q.wr;
                    if (fits(q.wr + PW'(3), q.rd)) begin
                        c_we   = 1'b1;
                        c_addr = q.wr[AW-1:0] + AW'(2);
                        d.sp   = q.wr + PW'(3);
                        d.drop = 1'b0;
                    end else begin
                        d.sp   = q.wr + PW'(2);
                        d.drop = 1'b1;
                    end
                end else begin
                    d.wid = q.wid + WID_W'(1);
                    if (!q.drop && fits(q.sp + PW'(1), q.rd)) begin
                        c_we   = 1'b1;
                        c_addr = q.sp[AW-1:0];
                        d.sp   = q.sp + PW'(1);
                    end else begin
                        d.drop = 1'b1;
                    end
                end
                close_d = s_last;
            end else begin
                close_d = q.open;
            end
        end

        if (close_d) begin
            d.open = 1'b0;
            if ((d.wid >= WID_W'(2)) || d.hi1) begin
                if (d.drop) begin
                    d.ovf = 1'b1;
                end else begin
                    h_we   = 1'b1;
                    h_addr = d.st[AW-1:0];
                    h_d0   = 8'(d.first);
                    h_d1   = 8'(d.wid);
                    d.wr   = d.sp;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign f_nempty = (q.wr != q.rd);
    assign ovf_flag = q.ovf;

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr - q.rd) <= PW'(FIFO_BYTES));

    // R8
    nempty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_nempty && !f_ren) |=> f_nempty);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R7
    frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_last) |=> !q.open);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> $stable(q.idx));

    // R5
    code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && pass_lo) |-> (code != 8'd0));

    // R4
    hdr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_we |-> (h_d1 != 8'd0));

endmodule

// File: tb/strip_cluster_finder_test.sv
`timescale 1ns/1ps
module strip_cluster_finder_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [5:0]         thr_lo = 6'd12;
    logic [5:0]         thr_hi = 6'd20;
    logic               s_valid = 1'b0;
    logic               s_last = 1'b0;
    logic signed [11:0] s_charge = '0;
    logic [7:0]         s_noise = '0;
    logic               f_ren = 1'b0;
    logic [7:0]         f_rdata;
    logic               f_nempty;
    logic               ovf_flag;

    always #2.5 clk = ~clk;

    strip_cluster_finder uut (
        .clk(clk), .rst_n(rst_n), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .s_valid(s_valid), .s_last(s_last), .s_charge(s_charge), .s_noise(s_noise),
        .f_ren(f_ren), .f_rdata(f_rdata), .f_nempty(f_nempty), .ovf_flag(ovf_flag)
    );

    int         ch [128];
    int         nz [128];
    bit         gap[128];
    bit [7:0]   expq[$];
    int         errors = 0;
    int         checks = 0;
    string      tag = "R8";
    bit         mon_en = 1'b1;
    bit         exp_ovf = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit [7:0] squeeze_m(int v);
        if (v <= 0) return 8'd0;
        if (v <= 253) return 8'(v);
        if (v <= 1023) return 8'd254;
        return 8'd255;
    endfunction

    function automatic void close_run(int first, int len, bit hi1);
        if (len >= 2 || hi1) begin
            if (expq.size() + len + 2 <= 2048) begin
                expq.push_back(8'(first));
                expq.push_back(8'(len));
                for (int k = first; k < first + len; k++) expq.push_back(squeeze_m(ch[k]));
            end else begin
                exp_ovf = 1'b1;
            end
        end
    endfunction

    function automatic void model(int n);
        int start = -1;
        int len = 0;
        bit hi1 = 1'b0;
        bit lo, hi;
        for (int i = 0; i < n; i++) begin
            lo = 4 * ch[i] > int'(thr_lo) * nz[i];
            hi = 4 * ch[i] > int'(thr_hi) * nz[i];
            if (lo) begin
                if (start < 0) begin start = i; len = 0; hi1 = hi; end
                len++;
                if (i == n - 1) begin close_run(start, len, hi1); start = -1; end
            end else if (start >= 0) begin
                close_run(start, len, hi1);
                start = -1;
            end
        end
    endfunction

    task automatic clear_frame();
        for (int i = 0; i < 128; i++) begin ch[i] = 0; nz[i] = 10; gap[i] = 1'b0; end
    endtask

    task automatic send(int n);
        model(n);
        for (int i = 0; i < n; i++) begin
            if (gap[i]) begin
                @(negedge clk);
                s_valid = 1'b0;
                s_charge = 12'sd999;
            end
            @(negedge clk);
            s_valid  = 1'b1;
            s_last   = (i == n - 1);
            s_charge = 12'(ch[i]);
            s_noise  = 8'(nz[i]);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        for (int w = 0; w < 5000; w++) begin
            if (expq.size() == 0 && !f_nempty) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(expq.size() == 0, {tag, " leftover expected bytes"}, expq.size(), 0);
        check(f_nempty == 1'b0, {tag, " unexpected extra bytes"}, int'(f_nempty), 0);
    endtask

    // Monitor: pop one expected byte for each byte the FIFO presents.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && f_nempty) begin
                if (expq.size() == 0) begin
                    check(1'b0, {tag, " unexpected byte"}, int'(f_rdata), -1);
                end else begin
                    automatic bit [7:0] e = expq.pop_front();
                    check(f_rdata == e, {tag, " record byte"}, int'(f_rdata), int'(e));
                end
                f_ren = 1'b1;
            end else begin
                f_ren = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_frame();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(f_nempty == 1'b0, "R8 reset empty", int'(f_nempty), 0);
        check(ovf_flag == 1'b0, "R9 reset flag", int'(ovf_flag), 0);

        // R1 R2: strict boundary, noise-scaled threshold, split runs
        tag = "R1 R2";
        clear_frame();
        ch[5] = 31; ch[6] = 40; ch[7] = 31; ch[8] = 30;
        ch[9] = 31; ch[10] = 35;
        nz[30] = 20; nz[31] = 20; nz[32] = 20;
        ch[30] = 61; ch[31] = 61; ch[32] = 60;
        send(128);
        drain();

        // R3: single strips at the high-threshold edge
        tag = "R3";
        clear_frame();
        ch[20] = 51; ch[40] = 50; ch[60] = 45;
        send(128);
        drain();

        // R5 R4: compression codes in order
        tag = "R5 R4";
        clear_frame();
        ch[50] = 253; ch[51] = 254; ch[52] = 1023; ch[53] = 1024; ch[54] = 2000; ch[55] = 1;
        nz[55] = 0;
        send(128);
        drain();

        // R7: run closed by frame end, new run at next frame start
        tag = "R7";
        clear_frame();
        ch[125] = 60; ch[126] = 70; ch[127] = 80;
        send(128);
        clear_frame();
        ch[0] = 90; ch[1] = 95;
        send(128);
        drain();

        // R6: index restart after a short frame
        tag = "R6";
        clear_frame();
        ch[8] = 44; ch[9] = 45;
        send(10);
        clear_frame();
        ch[2] = 70; ch[3] = 71;
        send(128);
        drain();

        // R10: idle cycles inside a run
        tag = "R10";
        clear_frame();
        ch[10] = 33; ch[11] = 34; ch[12] = 35;
        gap[11] = 1'b1; gap[12] = 1'b1; gap[40] = 1'b1;
        ch[41] = 60;
        send(128);
        drain();

        // R9: fill, exact fit, overflow
        tag = "R9 R8";
        mon_en = 1'b0;
        for (int f = 0; f < 20; f++) begin
            clear_frame();
            for (int i = 0; i < 100; i++) ch[i] = 100 + f + i;
            send(128);
        end
        clear_frame();
        ch[70] = 40;
        send(128);
        @(negedge clk);
        @(negedge clk);
        check(ovf_flag == 1'b0, "R9 rejected run on full FIFO", int'(ovf_flag), 0);
        clear_frame();
        for (int i = 0; i < 100; i++) ch[i] = 150;
        send(128);
        @(negedge clk);
        @(negedge clk);
        check(ovf_flag == 1'b1, "R9 flag after lost record", int'(ovf_flag), 1);
        clear_frame();
        ch[5] = 60;
        send(128);
        clear_frame();
        ch[7] = 31; ch[8] = 32; ch[9] = 33;
        send(128);
        clear_frame();
        ch[9] = 77;
        send(128);
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        repeat (3) @(negedge clk);
        check(expq.size() == 2048, "R9 model fill at capacity", expq.size(), 2048);
        check(f_nempty == 1'b1, "R8 full FIFO non-empty", int'(f_nempty), 1);
        mon_en = 1'b1;
        drain();
        check(ovf_flag == exp_ovf, "R9 flag held", int'(ovf_flag), int'(exp_ovf));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule